// File: doc/BRIEF.md
# Table-Coded Peripheral Bus Clock Divider

This block derives the peripheral bus clock from a faster source clock. Software writes a two-bit divide code into the low bits of a control word. The code does not act as a plain exponent. Codes 0 and 1 both give a divide ratio of two, code 2 gives four, and code 3 gives eight. The block therefore has no pass-through setting. The block drives two outputs. The first is a divided clock with an even high/low split. The second is a single-cycle enable pulse that marks the start of each divided period, for logic that stays on the source clock.

A new code never cuts a period short. The written value is kept in a holding field, and the counter picks it up only when its current period ends. The holding field reads back exactly as written, so code 0 and code 1 stay distinguishable to software even though they divide the same way. All control bits above the field read as zero.

Top module: `busclk_divider`

## Requirements
- R1: While rst_n is low, rd_data, div_clk and clk_en are all 0. The first period after reset uses code 0, which divides by 2.
- R2: With code 0 (field bits [1:0] = 2'b00) active, clk_en pulses every 2 source cycles.
- R3: With code 1 (field bits [1:0] = 2'b01) active, clk_en pulses every 2 source cycles, the same as code 0.
- R4: Code 2 (2'b10) gives a period of 4 source cycles. Code 3 (2'b11) gives a period of 8 source cycles.
- R5: One cycle after a write, rd_data[1:0] equals wr_data[1:0] of that write. Bits rd_data[7:2] always read 0.
- R6: A code written part-way through a period does not alter that period. It takes effect from the next period start.
- R7: In every period of N source cycles, div_clk is high for the first N/2 cycles and low for the last N/2.
- R8: clk_en is high for exactly one source cycle per period, in the cycle where div_clk rises.
- R9: Only the code held at a period boundary is applied. A code that is overwritten before the boundary never takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word; bits [1:0] hold the divide code |
| rd_data | output | 8 | Readback of the control word |
| div_clk | output | 1 | Divided clock, 50% duty |
| clk_en | output | 1 | One-cycle pulse at the start of each divided period |

## Verification
The hardest case is a code change that lands inside a long period. In that case the register already shows the new value, but the output must keep the old divisor. The worst form of this is two writes inside the same period, where the first value must vanish without a trace. To reach it, the stimulus switches to the divide-by-8 setting and aligns to an enable pulse. It then issues one or two writes in the next cycles and counts the source cycles up to the following pulses. A behavioural model tracks the holding field, the active code and the position in the period on every clock, and it is compared against all three outputs on every cycle.

// File: rtl/busdiv_pkg.sv
`timescale 1ns/1ps
package busdiv_pkg;

    // Power-of-two exponent for a divide code: the two lowest codes share
    // exponent 1, every higher code uses its own value as the exponent.
    function automatic int unsigned code_to_exp(input int unsigned code);
        return (code < 1) ? 1 : code;
    endfunction

endpackage

// File: rtl/busdiv_decode.sv
`timescale 1ns/1ps
module busdiv_decode #(
    parameter int FIELD_W = 2,
    parameter int CNT_W   = (1 << FIELD_W) - 1
) (
    input  logic [FIELD_W-1:0] code,
    output logic [CNT_W-1:0]   last_idx,
    output logic [CNT_W-1:0]   half_cnt
);
    import busdiv_pkg::*;

    int unsigned exp_v;

    always_comb begin
        exp_v    = code_to_exp(int'(code));
        last_idx = CNT_W'((1 << exp_v) - 1);
        half_cnt = CNT_W'(1 << (exp_v - 1));
    end

endmodule

// File: rtl/busdiv_field_reg.sv
`timescale 1ns/1ps
module busdiv_field_reg #(
    parameter int REG_W   = 8,
    parameter int FIELD_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [FIELD_W-1:0] field,
    output logic [REG_W-1:0]   rd_data
);
    typedef struct packed {
        logic [FIELD_W-1:0] code;
    } fr_state_t;

    fr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.code = wr_data[FIELD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign field   = st_q.code;
    assign rd_data = REG_W'(st_q.code);

endmodule

// File: rtl/busdiv_counter.sv
`timescale 1ns/1ps
module busdiv_counter #(
    parameter int FIELD_W = 2,
    parameter int CNT_W   = (1 << FIELD_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] pend_code,
    output logic [FIELD_W-1:0] act_code,
    output logic               div_clk,
    output logic               clk_en
);
    typedef struct packed {
        logic [FIELD_W-1:0] act;
        logic [CNT_W-1:0]   cnt;
        logic               clk_o;
        logic               en_o;
    } ct_state_t;

    ct_state_t st_d, st_q;

    logic [CNT_W-1:0]   cur_last, cur_half;
    logic [CNT_W-1:0]   nxt_last, nxt_half;
    logic               at_end;
    logic [FIELD_W-1:0] act_nxt;

    busdiv_decode #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_dec_cur (
        .code     (st_q.act),
        .last_idx (cur_last),
        .half_cnt (cur_half)
    );

    assign at_end  = (st_q.cnt == cur_last);
    assign act_nxt = at_end ? pend_code : st_q.act;

    busdiv_decode #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_dec_nxt (
        .code     (act_nxt),
        .last_idx (nxt_last),
        .half_cnt (nxt_half)
    );

    always_comb begin
        st_d     = st_q;
        st_d.act = act_nxt;
        if (at_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.clk_o = (st_d.cnt < nxt_half);
        st_d.en_o  = at_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act   <= '0;
            st_q.cnt   <= CNT_W'(1);
            st_q.clk_o <= 1'b0;
            st_q.en_o  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_code = st_q.act;
    assign div_clk  = st_q.clk_o;
    assign clk_en   = st_q.en_o;

endmodule

// File: rtl/busclk_divider.sv
`timescale 1ns/1ps
module busclk_divider #(
    parameter int REG_W   = 8,
    parameter int FIELD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             div_clk,
    output logic             clk_en
);
    localparam int CNT_W = (1 << FIELD_W) - 1;

    logic [FIELD_W-1:0] pend_code;
    logic [FIELD_W-1:0] act_code;

    busdiv_field_reg #(.REG_W(REG_W), .FIELD_W(FIELD_W)) u_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .field   (pend_code),
        .rd_data (rd_data)
    );

    busdiv_counter #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_code (pend_code),
        .act_code  (act_code),
        .div_clk   (div_clk),
        .clk_en    (clk_en)
    );

endmodule

// File: rtl/busclk_divider_chk.sv
`timescale 1ns/1ps
module busclk_divider_chk #(
    parameter int REG_W   = 8,
    parameter int FIELD_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [REG_W-1:0]   wr_data,
    input logic [REG_W-1:0]   rd_data,
    input logic               div_clk,
    input logic               clk_en,
    input logic [FIELD_W-1:0] act_code
);
    localparam int HALF_MAX = 1 << ((1 << FIELD_W) - 2);

    logic [3:0] run_q;
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 4'd0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= div_clk;
            if (div_clk != prev_q) begin
                run_q <= 4'd1;
            end else if (run_q != 4'd15) begin
                run_q <= run_q + 4'd1;
            end
        end
    end

    // R8
    en_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> (div_clk && !$past(div_clk)));

    // R8
    rise_has_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_clk) |-> clk_en);

    // R5
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[FIELD_W-1:0] == $past(wr_data[FIELD_W-1:0])));

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:FIELD_W] == '0);

    // R6
    swap_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_code) |-> clk_en);

    // R7
    half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_q) <= HALF_MAX);

endmodule

bind busclk_divider busclk_divider_chk #(.REG_W(REG_W), .FIELD_W(FIELD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .div_clk  (div_clk),
    .clk_en   (clk_en),
    .act_code (act_code)
);

// File: tb/busclk_divider_test.sv
`timescale 1ns/1ps
module busclk_divider_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       div_clk;
    logic       clk_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    // reference model state
    int m_field = 0;
    int m_act = 0;
    int m_pos = 1;
    int m_clk = 0;
    int m_en = 0;

    always #2.5 clk = ~clk;

    busclk_divider uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .div_clk (div_clk),
        .clk_en  (clk_en)
    );

    function automatic int ratio(input int code);
        case (code)
            0: return 2;
            1: return 2;
            2: return 4;
            default: return 8;
        endcase
    endfunction

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    // behavioural model: period position advances each clock, the held
    // code is adopted only when a period finishes
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_field = 0;
            m_act = 0;
            m_pos = 1;
            m_clk = 0;
            m_en = 0;
        end else begin
            if (m_pos == ratio(m_act) - 1) begin
                m_act = m_field;
                m_pos = 0;
            end else begin
                m_pos = m_pos + 1;
            end
            m_clk = (m_pos < ratio(m_act) / 2) ? 1 : 0;
            m_en = (m_pos == 0) ? 1 : 0;
            if (wr_en) m_field = int'(wr_data[1:0]);
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            check("R7 div_clk vs model", int'(div_clk), m_clk);
            check("R8 clk_en vs model", int'(clk_en), m_en);
            check("R5 rd_data vs model", int'(rd_data), m_field);
        end
    end

    task automatic do_write(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_en();
        while (!clk_en) @(negedge clk);
    endtask

    task automatic next_en();
        @(negedge clk);
        wait_en();
    endtask

    task automatic cycles_to_en(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!clk_en);
    endtask

    task automatic set_and_measure(input logic [7:0] v, input string tag, input int exp_n);
        int n;
        do_write(v);
        next_en();
        next_en();
        cycles_to_en(n);
        check(tag, n, exp_n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 rd_data in reset", int'(rd_data), 0);
        check("R1 div_clk in reset", int'(div_clk), 0);
        check("R1 clk_en in reset", int'(clk_en), 0);
        rst_n = 1'b1;
        next_en();
        cycles_to_en(n);
        check("R1 period after reset", n, 2);

        set_and_measure(8'h01, "R3 code 1 period", 2);
        set_and_measure(8'h02, "R4 code 2 period", 4);
        set_and_measure(8'h03, "R4 code 3 period", 8);
        set_and_measure(8'h00, "R2 code 0 period", 2);

        // R5 readback, upper bits dropped
        do_write(8'hFD);
        check("R5 readback of 0xFD", int'(rd_data), 1);
        do_write(8'h03);
        check("R5 readback of 3", int'(rd_data), 3);

        // R6 mid-period change keeps current period
        next_en();
        next_en();
        next_en();
        do_write(8'h00);
        n = 1;
        while (!clk_en) begin
            @(negedge clk);
            n++;
        end
        check("R6 period containing write", n, 8);
        cycles_to_en(n);
        check("R6 period after boundary", n, 2);

        // R9 overwritten code never applied
        do_write(8'h03);
        next_en();
        next_en();
        next_en();
        do_write(8'h02);
        do_write(8'h01);
        n = 2;
        while (!clk_en) begin
            @(negedge clk);
            n++;
        end
        check("R9 period with two writes", n, 8);
        cycles_to_en(n);
        check("R9 applied code is last", n, 2);
        cycles_to_en(n);
        check("R9 no trace of code 2", n, 2);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule